// File: doc/BRIEF.md
# Codec Serial Port Frame Controller

This block times the frames of a codec's serial data port and decides when the port drives its three pins: frame sync, bit clock and serial data. It takes a bit-clock edge strobe, a data/control mode input and the port configuration fields: frame size, master/slave, clock source, transmit disable and fast release. From these it keeps a bit position that wraps at the frame length, produces the bit clock level and a frame sync pulse, and drives one output enable for each pin. It does not shift sample data and does not decode control words.

The clock source and the port mode override some fields. Clock source code 0 forces slave operation, and in data mode it also forces a 256-bit frame. Leaving data mode releases all three pins, either on the next cycle or after a drain of three bit periods. The pins then stay released for a turnaround that lasts until the next bit boundary.

The mode sequencer has four states: CONTROL, DATA, DRAIN and TURNAROUND. Its transitions are named here. ENTER_DATA goes from CONTROL to DATA when the mode input is high. QUICK_DROP goes from DATA to TURNAROUND when the mode input is low and fast release is 1. SLOW_DROP goes from DATA to DRAIN when the mode input is low and fast release is 0. DRAIN_DONE goes from DRAIN to TURNAROUND on the third bit boundary counted in DRAIN. HANDBACK leaves TURNAROUND at the next bit boundary and goes to DATA or CONTROL, as the mode input selects.

Top module: `sport_frame_ctrl`

## Requirements
- R1: After reset the bit position is 0 and the bit clock level is 0. The sequencer is in CONTROL, so the data enable is 1. With the master/slave input at 0, the bit clock and frame sync enables are 0.
- R2: Each cycle with `sclk_edge` high toggles `sclk_out`. The bit position advances by one only on an edge where `sclk_out` was 1, and that edge is the bit boundary. On all other cycles the bit position holds.
- R3: Frame code 0 gives 64 bits per frame, code 1 gives 128, code 2 gives 256, and the reserved code 3 gives 256. A new frame length is loaded only when the position wraps to 0, so a change made mid-frame first applies to the following frame.
- R4: With clock source code 0 and `data_mode` high, the frame is 256 bits whatever the frame code. With `data_mode` low, the frame code applies.
- R5: `fsync_out` is 1 exactly while the bit position is 0, which is one bit period per frame.
- R6: The bit clock and frame sync enables are 1 in CONTROL, DATA and DRAIN only when `master_sel` is 1 and `clk_src` is not 0. Clock source 0 forces them to 0.
- R7: In DATA and DRAIN the data enable is the inverse of `tx_disable`. In CONTROL it is 1 whatever `tx_disable` holds.
- R8: In DATA with `fast_release` at 1, a low `data_mode` sampled at a clock edge makes all three enables 0 in the next cycle.
- R9: In DATA with `fast_release` at 0, a low `data_mode` keeps the enables at their data-mode values through the third following bit boundary. They are all 0 in the cycle after that boundary. The mode input is ignored during the drain.
- R10: In TURNAROUND all three enables are 0 until the next bit boundary. The following cycle is in DATA if `data_mode` is high at that boundary, and in CONTROL if it is low.
- R11: In CONTROL, a high `data_mode` moves the sequencer to DATA in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_edge | input | 1 | One-cycle strobe per bit-clock half period |
| data_mode | input | 1 | 1 = data mode, 0 = control mode |
| frame_code | input | 2 | Frame size field: 0=64, 1=128, 2=256, 3=256 |
| master_sel | input | 1 | 1 = drive bit clock and frame sync |
| clk_src | input | 3 | Clock source field; code 0 = port bit clock is the master clock |
| tx_disable | input | 1 | 1 = release serial data in data mode |
| fast_release | input | 1 | 1 = release pins on the cycle after leaving data mode |
| bit_pos | output | 8 | Bit position within the current frame |
| sclk_out | output | 1 | Bit clock level |
| fsync_out | output | 1 | Frame sync level |
| sclk_oe | output | 1 | Bit clock pin enable |
| fsync_oe | output | 1 | Frame sync pin enable |
| sdata_oe | output | 1 | Serial data pin enable |

## Verification
The enables decode the registered sequencer state. A mode or configuration change sampled at one rising edge therefore shows on the enables in the next cycle, and the bench reads them at the following falling edge. A bit-clock edge strobe changes `sclk_out` and `bit_pos` at the rising edge that samples it. The bench raises the strobe for exactly one cycle between two falling edges and samples after that edge. The slow release is checked on both sides of the third bit boundary: the enables are still on after the rising half of that bit and off after its falling half. Frame lengths are measured by counting bit boundaries from one wrap to the next, so the boundary-latching rule shows up as the length of the frame.

// File: rtl/sport_pkg.sv
package sport_pkg;
    typedef enum logic [1:0] {
        S_CTRL  = 2'd0,
        S_DATA  = 2'd1,
        S_DRAIN = 2'd2,
        S_TURN  = 2'd3
    } port_state_e;

    localparam logic [1:0] LEN_CODE_MAX = 2'd2;
endpackage

// File: rtl/sport_cfg_resolve.sv
module sport_cfg_resolve #(
    parameter int CLK_SRC_W = 3
) (
    input  logic [1:0]           frame_code,
    input  logic [CLK_SRC_W-1:0] clk_src,
    input  logic                 master_sel,
    input  logic                 data_mode,
    output logic                 master_eff,
    output logic [1:0]           len_code
);
    import sport_pkg::*;

    logic src_is_port_clk;

    always_comb begin
        src_is_port_clk = (clk_src == '0);
        master_eff      = master_sel && !src_is_port_clk;
        if (src_is_port_clk && data_mode)
            len_code = LEN_CODE_MAX;
        else if (frame_code > LEN_CODE_MAX)
            len_code = LEN_CODE_MAX;
        else
            len_code = frame_code;
    end
endmodule

// File: rtl/sport_bit_timer.sv
module sport_bit_timer #(
    parameter int BASE_BITS = 64,
    parameter int CW        = $clog2(BASE_BITS * 4)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_edge,
    input  logic [1:0]    len_code,
    output logic          sclk_q,
    output logic [CW-1:0] bit_pos,
    output logic          adv
);
    import sport_pkg::*;

    logic [1:0]  len_q;
    logic [CW:0] len_full;
    logic [CW-1:0] pos_last;

    always_comb begin
        adv      = sclk_edge && sclk_q;
        len_full = (CW+1)'(BASE_BITS) << len_q;
        pos_last = CW'(len_full - 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            bit_pos <= '0;
            len_q   <= LEN_CODE_MAX;
        end else begin
            if (sclk_edge)
                sclk_q <= !sclk_q;
            if (adv) begin
                if (bit_pos == pos_last) begin
                    bit_pos <= '0;
                    len_q   <= len_code;
                end else begin
                    bit_pos <= bit_pos + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sport_mode_fsm.sv
module sport_mode_fsm #(
    parameter int DRAIN_BITS = 3,
    localparam int DW = $clog2(DRAIN_BITS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   data_mode,
    input  logic                   fast_release,
    input  logic                   adv,
    input  logic                   master_eff,
    input  logic                   tx_disable,
    output sport_pkg::port_state_e state,
    output logic                   sclk_oe,
    output logic                   fsync_oe,
    output logic                   sdata_oe
);
    import sport_pkg::*;

    port_state_e state_nx;
    logic [DW-1:0] drain_cnt;
    logic drain_done;

    assign drain_done = adv && (drain_cnt == DW'(DRAIN_BITS - 1));

    always_comb begin
        state_nx = state;
        unique case (state)
            S_CTRL:  if (data_mode) state_nx = S_DATA;
            S_DATA:  if (!data_mode) state_nx = fast_release ? S_TURN : S_DRAIN;
            S_DRAIN: if (drain_done) state_nx = S_TURN;
            S_TURN:  if (adv) state_nx = data_mode ? S_DATA : S_CTRL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_CTRL;
            drain_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state != S_DRAIN)
                drain_cnt <= '0;
            else if (adv)
                drain_cnt <= drain_cnt + 1'b1;
        end
    end

    always_comb begin
        sclk_oe  = 1'b0;
        fsync_oe = 1'b0;
        sdata_oe = 1'b0;
        unique case (state)
            S_CTRL: begin
                sclk_oe  = master_eff;
                fsync_oe = master_eff;
                sdata_oe = 1'b1;
            end
            S_DATA, S_DRAIN: begin
                sclk_oe  = master_eff;
                fsync_oe = master_eff;
                sdata_oe = !tx_disable;
            end
            S_TURN: begin
                sclk_oe  = 1'b0;
                fsync_oe = 1'b0;
                sdata_oe = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sport_frame_ctrl.sv
module sport_frame_ctrl #(
    parameter int BASE_BITS  = 64,
    parameter int CLK_SRC_W  = 3,
    parameter int DRAIN_BITS = 3,
    localparam int CW = $clog2(BASE_BITS * 4)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk_edge,
    input  logic                 data_mode,
    input  logic [1:0]           frame_code,
    input  logic                 master_sel,
    input  logic [CLK_SRC_W-1:0] clk_src,
    input  logic                 tx_disable,
    input  logic                 fast_release,
    output logic [CW-1:0]        bit_pos,
    output logic                 sclk_out,
    output logic                 fsync_out,
    output logic                 sclk_oe,
    output logic                 fsync_oe,
    output logic                 sdata_oe
);
    import sport_pkg::*;

    logic        master_eff;
    logic [1:0]  len_code;
    logic        adv;
    port_state_e state;

    sport_cfg_resolve #(.CLK_SRC_W(CLK_SRC_W)) u_cfg (
        .frame_code (frame_code),
        .clk_src    (clk_src),
        .master_sel (master_sel),
        .data_mode  (data_mode),
        .master_eff (master_eff),
        .len_code   (len_code)
    );

    sport_bit_timer #(.BASE_BITS(BASE_BITS), .CW(CW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_edge (sclk_edge),
        .len_code  (len_code),
        .sclk_q    (sclk_out),
        .bit_pos   (bit_pos),
        .adv       (adv)
    );

    sport_mode_fsm #(.DRAIN_BITS(DRAIN_BITS)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .data_mode    (data_mode),
        .fast_release (fast_release),
        .adv          (adv),
        .master_eff   (master_eff),
        .tx_disable   (tx_disable),
        .state        (state),
        .sclk_oe      (sclk_oe),
        .fsync_oe     (fsync_oe),
        .sdata_oe     (sdata_oe)
    );

    assign fsync_out = (bit_pos == '0);
endmodule

// File: rtl/sport_frame_ctrl_chk.sv
module sport_frame_ctrl_chk #(
    parameter int CW        = 8,
    parameter int CLK_SRC_W = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sclk_edge,
    input logic                   data_mode,
    input logic                   fast_release,
    input logic [CLK_SRC_W-1:0]   clk_src,
    input logic [CW-1:0]          bit_pos,
    input logic                   sclk_out,
    input logic                   sclk_oe,
    input logic                   fsync_oe,
    input logic                   sdata_oe,
    input sport_pkg::port_state_e state
);
    import sport_pkg::*;

    p_pos_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_edge |=> $stable(bit_pos));

    p_sclk_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_edge |=> (sclk_out != $past(sclk_out)));

    p_wrap_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_edge && sclk_out && (bit_pos == {CW{1'b1}})) |=> (bit_pos == '0));

    p_slave_forced_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_src == '0) |-> (!sclk_oe && !fsync_oe));

    p_quick_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA && !data_mode && fast_release) |=> (!sclk_oe && !fsync_oe && !sdata_oe));

    p_enter_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CTRL && data_mode) |=> (state == S_DATA));
endmodule

bind sport_frame_ctrl sport_frame_ctrl_chk #(.CW(CW), .CLK_SRC_W(CLK_SRC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sclk_edge    (sclk_edge),
    .data_mode    (data_mode),
    .fast_release (fast_release),
    .clk_src      (clk_src),
    .bit_pos      (bit_pos),
    .sclk_out     (sclk_out),
    .sclk_oe      (sclk_oe),
    .fsync_oe     (fsync_oe),
    .sdata_oe     (sdata_oe),
    .state        (state)
);

// File: tb/sport_frame_ctrl_test.sv
`timescale 1ns/1ps
module sport_frame_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk_edge = 1'b0;
    logic       data_mode = 1'b0;
    logic [1:0] frame_code = 2'd0;
    logic       master_sel = 1'b0;
    logic [2:0] clk_src = 3'd1;
    logic       tx_disable = 1'b0;
    logic       fast_release = 1'b0;
    logic [7:0] bit_pos;
    logic       sclk_out, fsync_out, sclk_oe, fsync_oe, sdata_oe;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sport_frame_ctrl uut (
        .clk(clk), .rst_n(rst_n), .sclk_edge(sclk_edge), .data_mode(data_mode),
        .frame_code(frame_code), .master_sel(master_sel), .clk_src(clk_src),
        .tx_disable(tx_disable), .fast_release(fast_release), .bit_pos(bit_pos),
        .sclk_out(sclk_out), .fsync_out(fsync_out), .sclk_oe(sclk_oe),
        .fsync_oe(fsync_oe), .sdata_oe(sdata_oe)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic edge_pulse();
        @(negedge clk) sclk_edge = 1'b1;
        @(negedge clk) sclk_edge = 1'b0;
    endtask

    task automatic bit_period();
        edge_pulse();
        edge_pulse();
    endtask

    task automatic sync_frame();
        int n = 0;
        do begin
            bit_period();
            n++;
        end while (bit_pos != 0 && n < 400);
    endtask

    task automatic measure(input string tag, input int exp);
        int n = 0;
        do begin
            bit_period();
            n++;
        end while (bit_pos != 0 && n < 400);
        check(tag, n, exp);
    endtask

    task automatic t_reset();
        check("R1 bit_pos", bit_pos, 0);
        check("R1 sclk_out", sclk_out, 0);
        check("R1 sdata_oe", sdata_oe, 1);
        check("R1 sclk_oe", sclk_oe, 0);
        check("R1 fsync_oe", fsync_oe, 0);
    endtask

    task automatic t_clock_and_sync();
        edge_pulse();
        check("R2 sclk high after edge", sclk_out, 1);
        check("R2 pos holds on rising half", bit_pos, 0);
        check("R5 fsync at pos 0", fsync_out, 1);
        repeat (3) @(negedge clk);
        check("R2 pos holds without edge", bit_pos, 0);
        edge_pulse();
        check("R2 sclk low", sclk_out, 0);
        check("R2 pos advanced", bit_pos, 1);
        check("R5 fsync low at pos 1", fsync_out, 0);
    endtask

    task automatic t_control_enables();
        master_sel = 1'b1; clk_src = 3'd1; tx_disable = 1'b1;
        @(negedge clk);
        check("R6 master sclk_oe", sclk_oe, 1);
        check("R6 master fsync_oe", fsync_oe, 1);
        check("R7 ctrl ignores tx_disable", sdata_oe, 1);
        clk_src = 3'd0;
        @(negedge clk);
        check("R6 src0 forces slave sclk_oe", sclk_oe, 0);
        check("R6 src0 forces slave fsync_oe", fsync_oe, 0);
        clk_src = 3'd1;
        @(negedge clk);
    endtask

    task automatic t_enter_data();
        data_mode = 1'b1;
        @(negedge clk);
        check("R11 R7 data honours tx_disable", sdata_oe, 0);
        tx_disable = 1'b0;
        @(negedge clk);
        check("R7 data enable", sdata_oe, 1);
    endtask

    task automatic t_lengths();
        frame_code = 2'd0; sync_frame();
        measure("R3 code0 len", 64);
        repeat (10) bit_period();
        frame_code = 2'd1;
        measure("R3 mid-frame change deferred", 54);
        measure("R3 code1 len", 128);
        frame_code = 2'd2; sync_frame();
        measure("R3 code2 len", 256);
        frame_code = 2'd3; sync_frame();
        measure("R3 reserved code len", 256);
        frame_code = 2'd0; clk_src = 3'd0; sync_frame();
        measure("R4 src0 data forces 256", 256);
        clk_src = 3'd1; sync_frame();
        measure("R4 other source uses code", 64);
    endtask

    task automatic t_quick_release();
        fast_release = 1'b1; data_mode = 1'b0;
        @(negedge clk);
        check("R8 sdata_oe off", sdata_oe, 0);
        check("R8 sclk_oe off", sclk_oe, 0);
        check("R8 fsync_oe off", fsync_oe, 0);
        repeat (4) @(negedge clk);
        check("R10 held off", sclk_oe + sdata_oe + fsync_oe, 0);
        edge_pulse();
        check("R10 off before boundary", sclk_oe + sdata_oe + fsync_oe, 0);
        edge_pulse();
        check("R10 to control sdata_oe", sdata_oe, 1);
        check("R10 to control sclk_oe", sclk_oe, 1);
        data_mode = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_slow_release();
        fast_release = 1'b0; tx_disable = 1'b0; data_mode = 1'b0;
        @(negedge clk);
        check("R9 drain keeps sdata_oe", sdata_oe, 1);
        data_mode = 1'b1;
        bit_period();
        data_mode = 1'b0;
        bit_period();
        check("R9 drain after 2 bits", sclk_oe + sdata_oe + fsync_oe, 3);
        edge_pulse();
        check("R9 drain within 3rd bit", sclk_oe + sdata_oe + fsync_oe, 3);
        edge_pulse();
        check("R9 released after 3rd bit", sclk_oe + sdata_oe + fsync_oe, 0);
        data_mode = 1'b1; tx_disable = 1'b1;
        bit_period();
        check("R10 back to data sclk_oe", sclk_oe, 1);
        check("R10 back to data sdata_oe", sdata_oe, 0);
    endtask

    task automatic t_control_length();
        fast_release = 1'b1; data_mode = 1'b0;
        clk_src = 3'd0; frame_code = 2'd0;
        sync_frame();
        measure("R4 src0 control uses code", 64);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clock_and_sync();
        t_control_enables();
        t_enter_data();
        t_lengths();
        t_quick_release();
        t_slow_release();
        t_control_length();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule